// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches eight external interrupt pins and turns their activity into interrupt requests for a host processor. Each pin is first brought into the clock domain through a two-stage synchroniser. A programmable sense code then decides what counts as an event on that pin: a falling edge, a rising edge, either edge, a low level or a high level. Events latch a per-pin pending flag, and software reads these flags through a source register.

A pin drives its own request line only when three things are true: it is pending, it is not masked, and its 4-bit priority is non-zero. Software masks and unmasks pins through a pair of write-only registers. In one of them a 1 sets the mask bit, and in the other a 1 clears it. A combined request line is the OR of all per-pin lines.

In every register, pin 0 occupies the most significant field or bit, and higher pin numbers move toward the least significant end. Edge-triggered pending flags are cleared by writing 0 to their bit in the source register. Level-triggered flags simply track the synchronised pin level.

Top module: `xint_pin_ctrl`

## Requirements
- R1: After reset all sense fields read 0, all priority fields read 0, the source register reads 0, every pin is masked, and irq_o and irq_any_o are 0.
- R2: Register addresses are 0 for sense, 1 for priority, 2 for source, 3 for mask-set and 4 for mask-clear. Pin n's sense field starts at bit (7-n)*SENSE_W and its priority field starts at bit (7-n)*4. Both the sense and priority registers read back the programmed value, with bits above the used fields reading 0. Reads of addresses 3 and 4 return 0.
- R3: In sense code 1 (rising edge), a low-to-high transition on a pin sets its pending flag on the third rising clock edge after the change, and a high-to-low transition sets nothing.
- R4: In sense code 0 (falling edge), only a high-to-low transition sets the pending flag.
- R5: In sense code 4 (both edges), each transition in either direction sets the pending flag.
- R6: In sense codes 2 (low level) and 3 (high level), the pending flag follows the synchronised active level. Writing 0 to it in the source register has no effect while the level is active, and the flag drops once the level goes inactive.
- R7: Pin n's pending flag is bit SRC_W-1-n of the source register (bit 7 for pin 0 with the default width of 8), and it reads the same whether or not the pin is masked.
- R8: A write to the source register clears an edge-mode pending flag whose bit is written as 0 and keeps a flag whose bit is written as 1. Writing all zeros clears every edge-mode flag.
- R9: Writing 1 to bit SRC_W-1-n of the mask-set register masks pin n, and writing 1 to that bit of the mask-clear register unmasks it. Bits written as 0 in either register leave their pins unchanged.
- R10: irq_o[n] is 1 exactly when pin n is pending, unmasked and has a non-zero priority, and irq_any_o is the OR of irq_o.
- R11: Sense codes 5 to 15, which fit only in a 4-bit field, never set a pending flag, whatever the pin does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | N_PIN | Asynchronous external interrupt pins, bit n is pin n |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Register address for reads and writes |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| irq_o | output | N_PIN | Per-pin interrupt request, bit n is pin n |
| irq_any_o | output | 1 | OR of all per-pin requests |

## Verification
The pins are programmed with a different sense code each, so that the same stimulus (one pin toggling while the others stay still) shows whether the decoding selects the right detector for each pin and whether an event lands in the right bit of the reversed source register. A rising pulse is sampled one cycle before and in the cycle where the flag should appear, which distinguishes a correct two-flop synchroniser from a shorter or longer path. Clearing by writing zeros is tried on edge-mode pins and on an active level-mode pin, which tells a latched flag apart from a tracking one. Mask-set, mask-clear and zero-priority writes are mixed while flags stay pending, which separates the three gating terms of a request from one another and from the source readout.

// File: rtl/xint_pkg.sv
// Package: shared constants for the external interrupt pin controller.
// Assumes register addresses are compared against the zero-extended bus address.
package xint_pkg;
    // Register addresses
    localparam int ADR_SENSE = 0;
    localparam int ADR_PRIO  = 1;
    localparam int ADR_SRC   = 2;
    localparam int ADR_MSET  = 3;
    localparam int ADR_MCLR  = 4;

    // Sense codes
    typedef enum logic [7:0] {
        SNS_FALL = 8'd0,
        SNS_RISE = 8'd1,
        SNS_LOW  = 8'd2,
        SNS_HIGH = 8'd3,
        SNS_BOTH = 8'd4
    } sense_e;

    localparam int PRIO_W = 4;
endpackage

// File: rtl/xint_sync.sv
// Module: two-stage synchroniser for a vector of asynchronous inputs.
// Assumes each bit is independent; no multi-bit coherency is implied.
module xint_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg1_q;
    logic [W-1:0] stg2_q;

    // Shift the inputs through two flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg1_q <= '0;
            stg2_q <= '0;
        end else begin
            stg1_q <= d_i;
            stg2_q <= stg1_q;
        end
    end

    assign q_o = stg2_q;
endmodule

// File: rtl/xint_detect.sv
// Module: per-pin event detection and pending flags.
// Assumes pin_s is already synchronised; the sense word places pin 0 in the top field.
// Edge modes latch a flag until software clears it; level modes track the level.
module xint_detect
    import xint_pkg::*;
#(
    parameter int N_PIN   = 8,
    parameter int SENSE_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_PIN-1:0]           pin_s,
    input  logic [N_PIN*SENSE_W-1:0]   sense_f,
    input  logic                       src_we,
    input  logic [N_PIN-1:0]           src_keep,
    output logic [N_PIN-1:0]           pend_o
);
    for (genvar n = 0; n < N_PIN; n++) begin : g_pin
        logic               prev_q;
        logic               pend_q;
        logic [SENSE_W-1:0] code;
        logic [7:0]         code8;
        logic               ev;
        logic               lvl_mode;
        logic               lvl_act;
        logic               wipe;

        assign code  = sense_f[(N_PIN-1-n)*SENSE_W +: SENSE_W];
        assign code8 = 8'(code);
        assign wipe  = src_we & ~src_keep[n];

        // Decode the sense code into an event or a level condition
        always_comb begin
            ev       = 1'b0;
            lvl_mode = 1'b0;
            lvl_act  = 1'b0;
            case (code8)
                SNS_FALL: ev = ~pin_s[n] & prev_q;
                SNS_RISE: ev = pin_s[n] & ~prev_q;
                SNS_BOTH: ev = pin_s[n] ^ prev_q;
                SNS_LOW: begin
                    lvl_mode = 1'b1;
                    lvl_act  = ~pin_s[n];
                end
                SNS_HIGH: begin
                    lvl_mode = 1'b1;
                    lvl_act  = pin_s[n];
                end
                default: ev = 1'b0;
            endcase
        end

        // Remember the previous synchronised level for edge detection
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= pin_s[n];
        end

        // Update the pending flag; a new event wins over a clear
        always_ff @(posedge clk) begin
            if (!rst_n)        pend_q <= 1'b0;
            else if (lvl_mode) pend_q <= lvl_act;
            else               pend_q <= (pend_q & ~wipe) | ev;
        end

        assign pend_o[n] = pend_q;
    end
endmodule

// File: rtl/xint_regs.sv
// Module: register file for sense, priority, source and mask registers.
// Assumes one write per strobe cycle; reads are combinational from bus_addr.
// Source and mask bits use bit SRC_W-1-n for pin n.
module xint_regs
    import xint_pkg::*;
#(
    parameter int N_PIN   = 8,
    parameter int SENSE_W = 4,
    parameter int SRC_W   = 8,
    parameter int ADDR_W  = 3,
    parameter int DATA_W  = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_wr,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    input  logic [N_PIN-1:0]          pend,
    output logic [N_PIN*SENSE_W-1:0]  sense_q,
    output logic [N_PIN*PRIO_W-1:0]   prio_q,
    output logic [N_PIN-1:0]          mask_q,
    output logic                      src_we,
    output logic [N_PIN-1:0]          src_keep
);
    localparam int SNS_USED = N_PIN * SENSE_W;
    localparam int PRI_USED = N_PIN * PRIO_W;

    logic            wr_sense;
    logic            wr_prio;
    logic            wr_mset;
    logic            wr_mclr;
    logic [N_PIN-1:0] wbits;
    logic [SRC_W-1:0] src_view;

    assign wr_sense = bus_wr && (bus_addr == ADDR_W'(ADR_SENSE));
    assign wr_prio  = bus_wr && (bus_addr == ADDR_W'(ADR_PRIO));
    assign src_we   = bus_wr && (bus_addr == ADDR_W'(ADR_SRC));
    assign wr_mset  = bus_wr && (bus_addr == ADDR_W'(ADR_MSET));
    assign wr_mclr  = bus_wr && (bus_addr == ADDR_W'(ADR_MCLR));

    // Map reversed bus bits onto pin order
    for (genvar n = 0; n < N_PIN; n++) begin : g_map
        assign wbits[n]    = bus_wdata[SRC_W-1-n];
        assign src_view[SRC_W-1-n] = pend[n];
    end
    if (SRC_W > N_PIN) begin : g_src_pad
        assign src_view[SRC_W-N_PIN-1:0] = '0;
    end
    assign src_keep = wbits;

    // Hold the sense and priority fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sense_q <= '0;
            prio_q  <= '0;
        end else begin
            if (wr_sense) sense_q <= bus_wdata[SNS_USED-1:0];
            if (wr_prio)  prio_q  <= bus_wdata[PRI_USED-1:0];
        end
    end

    // Set or clear mask bits with write-one strobes
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '1;
        else if (wr_mset) mask_q <= mask_q | wbits;
        else if (wr_mclr) mask_q <= mask_q & ~wbits;
    end

    // Select read data by address
    always_comb begin
        bus_rdata = '0;
        case (int'(bus_addr))
            ADR_SENSE: bus_rdata = DATA_W'(sense_q);
            ADR_PRIO:  bus_rdata = DATA_W'(prio_q);
            ADR_SRC:   bus_rdata = DATA_W'(src_view);
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/xint_pin_ctrl.sv
// Module: top of the external interrupt pin controller.
// Assumes N_PIN*SENSE_W and N_PIN*4 fit in DATA_W and SRC_W >= N_PIN.
// Requests combine pending, mask and non-zero priority per pin.
module xint_pin_ctrl
    import xint_pkg::*;
#(
    parameter int N_PIN   = 8,
    parameter int SENSE_W = 4,
    parameter int SRC_W   = 8,
    parameter int ADDR_W  = 3,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PIN-1:0]  pin_i,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [N_PIN-1:0]  irq_o,
    output logic              irq_any_o
);
    logic [N_PIN-1:0]         pin_s;
    logic [N_PIN-1:0]         pend;
    logic [N_PIN*SENSE_W-1:0] sense_q;
    logic [N_PIN*PRIO_W-1:0]  prio_q;
    logic [N_PIN-1:0]         mask_q;
    logic                     src_we;
    logic [N_PIN-1:0]         src_keep;

    xint_sync #(.W(N_PIN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .q_o   (pin_s)
    );

    xint_detect #(.N_PIN(N_PIN), .SENSE_W(SENSE_W)) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_s    (pin_s),
        .sense_f  (sense_q),
        .src_we   (src_we),
        .src_keep (src_keep),
        .pend_o   (pend)
    );

    xint_regs #(
        .N_PIN(N_PIN), .SENSE_W(SENSE_W), .SRC_W(SRC_W),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pend      (pend),
        .sense_q   (sense_q),
        .prio_q    (prio_q),
        .mask_q    (mask_q),
        .src_we    (src_we),
        .src_keep  (src_keep)
    );

    // Gate each pending flag by mask and priority
    for (genvar n = 0; n < N_PIN; n++) begin : g_req
        assign irq_o[n] = pend[n] & ~mask_q[n]
                        & (|prio_q[(N_PIN-1-n)*PRIO_W +: PRIO_W]);
    end

    assign irq_any_o = |irq_o;
endmodule

// File: rtl/xint_pin_ctrl_chk.sv
// Module: assertion checker bound to the interrupt pin controller top.
// Assumes the same parameters as the bound instance.
module xint_pin_ctrl_chk
    import xint_pkg::*;
#(
    parameter int N_PIN   = 8,
    parameter int SENSE_W = 4,
    parameter int SRC_W   = 8,
    parameter int ADDR_W  = 3,
    parameter int DATA_W  = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bus_wr,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic [DATA_W-1:0]        bus_wdata,
    input logic [N_PIN-1:0]         irq_o,
    input logic                     irq_any_o,
    input logic [N_PIN*SENSE_W-1:0] sense_q,
    input logic [N_PIN-1:0]         mask_q
);
    logic [N_PIN-1:0] wr_pins;

    for (genvar n = 0; n < N_PIN; n++) begin : g_rev
        assign wr_pins[n] = bus_wdata[SRC_W-1-n];
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mask_q == '1 && irq_o == '0 && !irq_any_o));

    // R2
    sense_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(ADR_SENSE))
        |=> (sense_q == $past(bus_wdata[N_PIN*SENSE_W-1:0])));

    // R9
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(ADR_MSET))
        |=> ((irq_o & $past(wr_pins)) == '0));

    // R10
    prio_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(ADR_PRIO) && bus_wdata == '0)
        |=> !irq_any_o);
endmodule

bind xint_pin_ctrl xint_pin_ctrl_chk #(
    .N_PIN(N_PIN), .SENSE_W(SENSE_W), .SRC_W(SRC_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_o     (irq_o),
    .irq_any_o (irq_any_o),
    .sense_q   (sense_q),
    .mask_q    (mask_q)
);

// File: tb/test_xint_pin_ctrl.sv
`timescale 1ns/1ps
// Bench: scoreboard for the interrupt pin controller. Driver tasks queue
// expected values; a monitor process samples the outputs and compares.
module test_xint_pin_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pin_i = 8'h00;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [7:0]  irq_o;
    logic        irq_any_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    typedef struct {
        string       req;
        int          kind;
        logic [31:0] exp;
    } item_t;

    item_t q[$];
    event  chk_ev;

    always #2.5 clk = ~clk;

    xint_pin_ctrl i_xint_pin_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pin_i),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o),
        .irq_any_o (irq_any_o)
    );

    // Monitor: pop expected items and compare with the sampled outputs
    initial begin
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                if (it.kind == 0)      act = bus_rdata;
                else if (it.kind == 1) act = {24'h0, irq_o};
                else                   act = {31'h0, irq_any_o};
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s act=%h exp=%h", it.req, act, it.exp);
                end
            end
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic expect_reg(string req, logic [2:0] a, logic [31:0] e);
        item_t it;
        bus_addr = a;
        #0.5;
        it.req = req; it.kind = 0; it.exp = e;
        q.push_back(it);
        ->chk_ev;
        #0.5;
    endtask

    task automatic expect_irq(string req, logic [7:0] e, logic any);
        item_t it;
        #0.5;
        it.req = req; it.kind = 1; it.exp = {24'h0, e};
        q.push_back(it);
        it.kind = 2; it.exp = {31'h0, any};
        q.push_back(it);
        ->chk_ev;
        #0.5;
    endtask

    task automatic set_pin(int k, logic v);
        @(negedge clk);
        pin_i[k] = v;
    endtask

    // Stimulus
    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(1);
        expect_reg("R1 sense", 3'd0, 32'h0);
        expect_reg("R1 prio", 3'd1, 32'h0);
        expect_reg("R1 source", 3'd2, 32'h0);
        expect_irq("R1 irq", 8'h00, 1'b0);

        // Priorities on: all still masked
        bus_write(3'd1, 32'hFFFF_FFFF);
        expect_reg("R2 prio readback", 3'd1, 32'hFFFF_FFFF);
        expect_irq("R1 masked after reset", 8'h00, 1'b0);
        expect_reg("R2 mask-set reads 0", 3'd3, 32'h0);

        // pin0 rise, pin1 fall, pin2 both, pin3 high, pin4 low, pin5 invalid, pin6/7 rise
        bus_write(3'd0, 32'h1043_2711);
        expect_reg("R2 sense readback", 3'd0, 32'h1043_2711);
        wait_cyc(2);
        expect_reg("R6 low level pending", 3'd2, 32'h08);
        bus_write(3'd4, 32'hFF);
        expect_irq("R10 unmasked level pin4", 8'h10, 1'b1);
        bus_write(3'd2, 32'h00);
        expect_reg("R6 clear ignored while active", 3'd2, 32'h08);
        set_pin(4, 1'b1);
        wait_cyc(4);
        expect_reg("R6 level released", 3'd2, 32'h00);

        // Rising on pin0 with latency check
        set_pin(0, 1'b1);
        wait_cyc(2);
        expect_reg("R3 not yet pending", 3'd2, 32'h00);
        wait_cyc(1);
        expect_reg("R3 rise pending", 3'd2, 32'h80);
        set_pin(0, 1'b0);
        wait_cyc(4);
        expect_reg("R3 fall ignored", 3'd2, 32'h80);

        // Falling on pin1
        set_pin(1, 1'b1);
        wait_cyc(4);
        expect_reg("R4 rise ignored", 3'd2, 32'h80);
        set_pin(1, 1'b0);
        wait_cyc(4);
        expect_reg("R4 fall pending", 3'd2, 32'hC0);

        // Both edges on pin2, with selective clear
        set_pin(2, 1'b1);
        wait_cyc(4);
        expect_reg("R5 rise pending", 3'd2, 32'hE0);
        bus_write(3'd2, 32'hDF);
        expect_reg("R8 selective clear", 3'd2, 32'hC0);
        set_pin(2, 1'b0);
        wait_cyc(4);
        expect_reg("R5 fall pending", 3'd2, 32'hE0);

        // High level on pin3
        set_pin(3, 1'b1);
        wait_cyc(4);
        expect_reg("R6 high level pending", 3'd2, 32'hF0);
        set_pin(3, 1'b0);
        wait_cyc(4);
        expect_reg("R6 high level released", 3'd2, 32'hE0);

        // Invalid code on pin5
        set_pin(5, 1'b1);
        wait_cyc(4);
        set_pin(5, 1'b0);
        wait_cyc(4);
        expect_reg("R11 invalid code inert", 3'd2, 32'hE0);

        // Gating by mask and priority
        expect_irq("R10 three pending", 8'h07, 1'b1);
        bus_write(3'd3, 32'h80);
        expect_irq("R9 mask pin0", 8'h06, 1'b1);
        bus_write(3'd3, 32'h00);
        expect_irq("R9 zero bits no effect", 8'h06, 1'b1);
        expect_reg("R7 source ignores mask", 3'd2, 32'hE0);
        bus_write(3'd1, 32'hF0FF_FFFF);
        expect_irq("R10 prio zero pin1", 8'h04, 1'b1);
        bus_write(3'd4, 32'h80);
        expect_irq("R9 unmask pin0", 8'h05, 1'b1);
        bus_write(3'd4, 32'h00);
        expect_irq("R9 zero clear no effect", 8'h05, 1'b1);

        // Clear all edge flags
        bus_write(3'd2, 32'h00);
        expect_reg("R8 clear all", 3'd2, 32'h00);
        expect_irq("R8 no requests", 8'h00, 1'b0);

        wait_cyc(2);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule